// File: doc/BRIEF.md
# Nonvolatile Memory Protection Controller

This block keeps the protection setting of a small nonvolatile array and judges every write-type memory command against it. While the chip starts up, the block copies in a protection byte that is stored in the array. After that, software can read the setting through an 8-bit register port and can make it stricter. Software cannot make it looser. Only the next reset can relax it again.

Each command is judged in the cycle it is presented. A command is a program, a sector erase or a mass erase, together with a byte offset. The block answers with either grant or deny. A denied command must not be carried out by the array sequencer. A denial also sets a sticky violation flag, which software clears through a dedicated clear input. When the range is enabled, the protected window always ends at the top offset of the array. Its size doubles with each step of a 3-bit code. Mass erase follows a stricter rule than the other commands.

Top module: `nvp_protect_ctrl`

## Requirements
- R1: While reset is asserted, and until something else is loaded or written, `reg_rdata` reads 0xFF and `viol_flag` reads 0. With `cmd_valid` low, neither `cmd_grant` nor `cmd_deny` is high.
- R2: `load_valid` high copies all 8 bits of `load_data` (the stored protection byte at offset 0xFFD) into the register at the next edge. A load overrides a bus write in the same cycle.
- R3: Register layout: bit 7 is the open enable, bits 6:4 are reserved, bit 3 is the range disable and bits 2:0 are the size code. A bus write leaves bits 6:4 unchanged.
- R4: A bus write can only clear bit 7 and bit 3. Writing 1 to either bit while it is 0 leaves it at 0.
- R5: A bus write updates bits 2:0 only when bit 3 is 1 before that write. While bit 3 is 0, bits 2:0 keep their value.
- R6: `cmd_op` encodes 0 = program, 1 = sector erase, 2 = mass erase and 3 = reserved. While `cmd_valid` is high, exactly one of `cmd_grant` and `cmd_deny` is high, decided in the same cycle. While `cmd_valid` is low, both are low.
- R7: With bit 7 at 0, every command is denied.
- R8: With bits 7 and 3 both at 1, program and sector erase are granted at any offset.
- R9: With bit 7 at 1 and bit 3 at 0, the protected window starts at 4096 - min(4096, 64·2^code) and runs to 0xFFF. A program is denied exactly when its offset lies at or above that start.
- R10: A sector erase covers the 4-byte sector that contains the offset. It is denied when any byte of that sector lies in the window.
- R11: A mass erase is granted only when bits 7 and 3 are both 1.
- R12: The reserved opcode 3 is always denied.
- R13: A denied command sets `viol_flag` at the next edge. `viol_clr` clears it at the next edge. A denial in the same cycle as a clear leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_valid | input | 1 | Startup load strobe for the stored protection byte |
| load_data | input | 8 | Stored protection byte |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Current protection register |
| cmd_valid | input | 1 | Memory command present |
| cmd_op | input | 2 | Command type |
| cmd_addr | input | 12 | Byte offset of the command |
| cmd_grant | output | 1 | Command allowed |
| cmd_deny | output | 1 | Command blocked |
| viol_clr | input | 1 | Clear the violation flag |
| viol_flag | output | 1 | Sticky protection violation |

## Verification
The bench builds the block with its defaults: a 4096-byte array, 4-byte sectors and a 64-byte base window. With these values, all eight size codes can be reached, including the two codes that cover the whole array, one of which gives a window that has to be clipped. At each code, the bench probes the offsets just below and at the window start, as well as the top and bottom of the array. This covers both the exact window edge and the sector-rounding rule. The same values keep write-only-toward-protection and load-over-write collisions in a few dozen cycles.

// File: rtl/nvp_pkg.sv
package nvp_pkg;
  typedef enum logic [1:0] {
    NVP_OP_PROG = 2'd0,
    NVP_OP_SECT = 2'd1,
    NVP_OP_MASS = 2'd2,
    NVP_OP_RSVD = 2'd3
  } nvp_op_e;

  localparam int NVP_CODE_W = 3;

  typedef struct packed {
    logic                  open_en;
    logic [2:0]            rsvd;
    logic                  range_dis;
    logic [NVP_CODE_W-1:0] size_code;
  } nvp_prot_t;
endpackage

// File: rtl/nvp_prot_reg.sv
module nvp_prot_reg
  import nvp_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      load_valid,
  input  nvp_prot_t load_data,
  input  logic      wr_en,
  input  nvp_prot_t wr_data,
  output nvp_prot_t prot_q
);
  nvp_prot_t prot_d;
  logic      prot_en;

  always_comb begin
    prot_en = load_valid | wr_en;
    prot_d  = prot_q;
    if (load_valid) begin
      prot_d = load_data;
    end else if (wr_en) begin
      // protection bits may only move toward 0
      prot_d.open_en   = prot_q.open_en & wr_data.open_en;
      prot_d.range_dis = prot_q.range_dis & wr_data.range_dis;
      // size code follows the write only while the range is still disabled
      if (prot_q.range_dis) prot_d.size_code = wr_data.size_code;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       prot_q <= '1;
    else if (prot_en) prot_q <= prot_d;
  end
endmodule

// File: rtl/nvp_window.sv
module nvp_window
  import nvp_pkg::*;
#(
  parameter int MEM_BYTES  = 4096,
  parameter int BASE_BYTES = 64,
  localparam int SPAN_W    = $clog2(MEM_BYTES) + 1
) (
  input  logic [NVP_CODE_W-1:0] size_code,
  output logic [SPAN_W-1:0]     win_start
);
  localparam int NCODES = 1 << NVP_CODE_W;

  logic [SPAN_W-1:0] start_tab [NCODES];

  for (genvar c = 0; c < NCODES; c++) begin : g_code
    localparam int SZ = BASE_BYTES * (2 ** c);
    localparam int ST = (SZ >= MEM_BYTES) ? 0 : MEM_BYTES - SZ;
    assign start_tab[c] = SPAN_W'(ST);
  end

  assign win_start = start_tab[size_code];
endmodule

// File: rtl/nvp_judge.sv
module nvp_judge
  import nvp_pkg::*;
#(
  parameter int ADDR_W       = 12,
  parameter int SECTOR_BYTES = 4
) (
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  nvp_prot_t         prot,
  input  logic [ADDR_W:0]   win_start,
  output logic              grant,
  output logic              deny
);
  localparam int SEC_W = $clog2(SECTOR_BYTES);

  logic [ADDR_W-1:0] sec_last;
  logic              hit_byte, hit_sect, allow;

  if (SEC_W > 0) begin : g_sect
    assign sec_last = {cmd_addr[ADDR_W-1:SEC_W], {SEC_W{1'b1}}};
  end else begin : g_byte
    assign sec_last = cmd_addr;
  end

  assign hit_byte = {1'b0, cmd_addr} >= win_start;
  assign hit_sect = {1'b0, sec_last} >= win_start;

  always_comb begin
    allow = 1'b0;
    case (nvp_op_e'(cmd_op))
      NVP_OP_PROG: allow = prot.open_en & (prot.range_dis | ~hit_byte);
      NVP_OP_SECT: allow = prot.open_en & (prot.range_dis | ~hit_sect);
      NVP_OP_MASS: allow = prot.open_en & prot.range_dis;
      default:     allow = 1'b0;
    endcase
  end

  assign grant = cmd_valid & allow;
  assign deny  = cmd_valid & ~allow;
endmodule

// File: rtl/nvp_protect_ctrl.sv
module nvp_protect_ctrl
  import nvp_pkg::*;
#(
  parameter int MEM_BYTES    = 4096,
  parameter int SECTOR_BYTES = 4,
  parameter int BASE_BYTES   = 64,
  localparam int ADDR_W      = $clog2(MEM_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_valid,
  input  logic [7:0]        load_data,
  input  logic              reg_wr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  output logic              cmd_grant,
  output logic              cmd_deny,
  input  logic              viol_clr,
  output logic              viol_flag
);
  logic [1:0]      rst_pipe;
  logic            rst_sync_n;
  nvp_prot_t       prot_q;
  logic [ADDR_W:0] win_start;
  logic            viol_d, viol_en;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  nvp_prot_reg u_reg (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .load_valid (load_valid),
    .load_data  (nvp_prot_t'(load_data)),
    .wr_en      (reg_wr),
    .wr_data    (nvp_prot_t'(reg_wdata)),
    .prot_q     (prot_q)
  );

  nvp_window #(.MEM_BYTES(MEM_BYTES), .BASE_BYTES(BASE_BYTES)) u_win (
    .size_code (prot_q.size_code),
    .win_start (win_start)
  );

  nvp_judge #(.ADDR_W(ADDR_W), .SECTOR_BYTES(SECTOR_BYTES)) u_judge (
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .cmd_addr  (cmd_addr),
    .prot      (prot_q),
    .win_start (win_start),
    .grant     (cmd_grant),
    .deny      (cmd_deny)
  );

  always_comb begin
    viol_en = cmd_deny | viol_clr;
    viol_d  = cmd_deny;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  viol_flag <= 1'b0;
    else if (viol_en) viol_flag <= viol_d;
  end

  assign reg_rdata = prot_q;
endmodule

// File: rtl/nvp_protect_sva.sv
module nvp_protect_sva #(
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              load_valid,
  input logic [7:0]        load_data,
  input logic              reg_wr,
  input logic [7:0]        reg_wdata,
  input logic [7:0]        reg_rdata,
  input logic              cmd_valid,
  input logic [1:0]        cmd_op,
  input logic [ADDR_W-1:0] cmd_addr,
  input logic              cmd_grant,
  input logic              cmd_deny,
  input logic              viol_clr,
  input logic              viol_flag
);
  // R2
  load_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_valid |=> reg_rdata == $past(load_data));
  // R3
  rsvd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load_valid |=> reg_rdata[6:4] == $past(reg_rdata[6:4]));
  // R4
  open_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_rdata[7] && !load_valid) |=> !reg_rdata[7]);
  // R4
  rdis_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_rdata[3] && !load_valid) |=> !reg_rdata[3]);
  // R5
  size_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_rdata[3] && !load_valid) |=> $stable(reg_rdata[2:0]));
  // R5
  size_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !load_valid && reg_rdata[3]) |=> reg_rdata[2:0] == $past(reg_wdata[2:0]));
  // R6
  one_answer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({cmd_grant, cmd_deny}) == (cmd_valid ? 1 : 0));
  // R7
  closed_deny_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !reg_rdata[7]) |-> cmd_deny);
  // R8
  open_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op[1] == 1'b0 && reg_rdata[7] && reg_rdata[3]) |-> cmd_grant);
  // R9
  top_prot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 2'd0 && reg_rdata[7] && !reg_rdata[3] && (&cmd_addr)) |-> cmd_deny);
  // R11
  mass_rule_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 2'd2) |-> cmd_grant == (reg_rdata[7] && reg_rdata[3]));
  // R13
  viol_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_deny |=> viol_flag);
  // R13
  viol_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (viol_clr && !cmd_deny) |=> !viol_flag);
endmodule

bind nvp_protect_ctrl nvp_protect_sva #(.ADDR_W(ADDR_W)) u_sva (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .load_valid (load_valid),
  .load_data  (load_data),
  .reg_wr     (reg_wr),
  .reg_wdata  (reg_wdata),
  .reg_rdata  (reg_rdata),
  .cmd_valid  (cmd_valid),
  .cmd_op     (cmd_op),
  .cmd_addr   (cmd_addr),
  .cmd_grant  (cmd_grant),
  .cmd_deny   (cmd_deny),
  .viol_clr   (viol_clr),
  .viol_flag  (viol_flag)
);

// File: tb/nvp_protect_ctrl_test.sv
`timescale 1ns/1ps
module nvp_protect_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        load_valid;
  logic [7:0]  load_data;
  logic        reg_wr;
  logic [7:0]  reg_wdata;
  logic [7:0]  reg_rdata;
  logic        cmd_valid;
  logic [1:0]  cmd_op;
  logic [11:0] cmd_addr;
  logic        cmd_grant, cmd_deny;
  logic        viol_clr;
  logic        viol_flag;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [7:0] m_reg;
  bit         m_flag;

  always #2.5 clk = ~clk;

  nvp_protect_ctrl uut (
    .clk(clk), .rst_n(rst_n), .load_valid(load_valid), .load_data(load_data),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
    .cmd_grant(cmd_grant), .cmd_deny(cmd_deny),
    .viol_clr(viol_clr), .viol_flag(viol_flag)
  );

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic int win_start();
    int sz;
    sz = 64 * (1 << m_reg[2:0]);
    if (sz > 4096) sz = 4096;
    return 4096 - sz;
  endfunction

  function automatic bit model_ok(input logic [1:0] op, input int a);
    int last;
    last = (op == 2'd1) ? (a | 3) : a;
    case (op)
      2'd3:    return 1'b0;
      2'd2:    return m_reg[7] && m_reg[3];
      default: return m_reg[7] && (m_reg[3] || last < win_start());
    endcase
  endfunction

  task automatic cyc(input string tag, input bit ld, input logic [7:0] ldd,
                     input bit wr, input logic [7:0] wd,
                     input bit v, input logic [1:0] op, input int a, input bit clr);
    bit ok;
    load_valid = ld; load_data = ldd; reg_wr = wr; reg_wdata = wd;
    cmd_valid = v; cmd_op = op; cmd_addr = a[11:0]; viol_clr = clr;
    #1;
    ok = model_ok(op, a);
    check(tag, "reg_rdata", reg_rdata, m_reg);
    check(tag, "cmd_grant", cmd_grant, v && ok);
    check(tag, "cmd_deny",  cmd_deny,  v && !ok);
    check(tag, "viol_flag", viol_flag, m_flag);
    @(posedge clk);
    if (v && !ok)  m_flag = 1'b1;
    else if (clr)  m_flag = 1'b0;
    if (ld) m_reg = ldd;
    else if (wr) begin
      m_reg[7] = m_reg[7] & wd[7];
      if (m_reg[3]) m_reg[2:0] = wd[2:0];
      m_reg[3] = m_reg[3] & wd[3];
    end
    @(negedge clk);
  endtask

  task automatic idle(input string tag);
    cyc(tag, 0, 8'h00, 0, 8'h00, 0, 2'd0, 0, 0);
  endtask

  task automatic cmd(input string tag, input logic [1:0] op, input int a);
    cyc(tag, 0, 8'h00, 0, 8'h00, 1, op, a, 0);
  endtask

  task automatic load(input string tag, input logic [7:0] b);
    cyc(tag, 1, b, 0, 8'h00, 0, 2'd0, 0, 0);
  endtask

  task automatic wr(input string tag, input logic [7:0] d);
    cyc(tag, 0, 8'h00, 1, d, 0, 2'd0, 0, 0);
  endtask

  task automatic clr(input string tag);
    cyc(tag, 0, 8'h00, 0, 8'h00, 0, 2'd0, 0, 1);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    load_valid = 0; load_data = 0; reg_wr = 0; reg_wdata = 0;
    cmd_valid = 0; cmd_op = 0; cmd_addr = 0; viol_clr = 0;
    m_reg = 8'hFF; m_flag = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    // R1 values held during reset
    check("R1", "reg_rdata in reset", reg_rdata, 8'hFF);
    check("R1", "viol_flag in reset", viol_flag, 0);
    check("R1", "grant/deny idle", {cmd_grant, cmd_deny}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    idle("R1");
    idle("R6");

    // R8 fully open after reset; R11 mass erase allowed
    for (int i = 0; i < 3; i++) begin
      int a;
      a = (i == 0) ? 0 : (i == 1) ? 12'h7FF : 12'hFFF;
      cmd("R8", 2'd0, a);
      cmd("R8", 2'd1, a);
    end
    cmd("R11", 2'd2, 0);

    // R12 reserved opcode, R13 sticky flag and clear priority
    cmd("R12", 2'd3, 12'h100);
    idle("R13");
    clr("R13");
    idle("R13");
    cmd("R12", 2'd3, 0);
    cyc("R13", 0, 8'h00, 0, 8'h00, 1, 2'd3, 0, 1);
    idle("R13");
    clr("R13");

    // R5 size code writable while range disabled; R3 reserved bits ignore writes
    for (int c = 0; c < 8; c++) wr("R5", 8'h88 | 8'(c));
    wr("R3", 8'h8D);
    idle("R3");

    // R9/R10/R11 window per code, opened via startup load (R2)
    for (int c = 0; c < 8; c++) begin
      int st;
      load("R2", 8'hF0 | 8'(c));
      st = win_start();
      if (st > 0) begin
        cmd("R9", 2'd0, st - 1);
        cmd("R10", 2'd1, st - 1);
        cmd("R10", 2'd1, st - 4);
      end
      cmd("R9", 2'd0, st);
      cmd("R10", 2'd1, st);
      cmd("R10", 2'd1, st + 2);
      cmd("R9", 2'd0, 12'hFFF);
      cmd("R9", 2'd0, 0);
      cmd("R11", 2'd2, 12'h040);
      clr("R13");
    end

    // R4 open enable only clears; R7 closed array denies all
    load("R2", 8'hFF);
    wr("R4", 8'h7F);
    wr("R4", 8'hFF);
    cmd("R7", 2'd0, 0);
    cmd("R7", 2'd1, 12'h200);
    cmd("R7", 2'd2, 0);
    clr("R13");

    // R4 range disable only clears; R5 size frozen afterwards
    load("R2", 8'hFF);
    wr("R4", 8'hF7);
    wr("R5", 8'hFA);
    wr("R4", 8'hFF);
    cmd("R9", 2'd0, 0);
    cmd("R9", 2'd0, 12'hFFF);

    // R2 load beats same-cycle write
    cyc("R2", 1, 8'hF9, 1, 8'h00, 0, 2'd0, 0, 0);
    idle("R2");
    idle("R6");

    done = 1;
    summary();
    $finish;
  end
endmodule